// File: doc/BRIEF.md
# Periodic Rate and Square-Wave Generator

This block divides a reference clock into a one-hertz calendar tick and a selectable periodic rate. The reference clock is presented as a single-cycle enable, `ref_en`, in the system clock domain; one pulse stands for one period of a 32.768 kHz reference. A 15-stage binary prescaler counts those pulses and produces `sec_tick` once every 32768 of them. A separate phase counter, paced by the same pulses, produces `per_tick` once per period of the selected rate. When the square-wave enable is set, it also drives a square wave at that rate onto `sqw_out`.

A 3-bit divider selector controls the prescaler. Only the 32.768 kHz code lets the chain advance. The two codes with both upper bits set hold the chain cleared. All remaining codes (the 4.194 MHz and 1.049 MHz selections and the test codes) are decoded but only freeze the chain where it stands. A 4-bit rate code picks a power-of-two period. Code 0 switches the periodic output off. Any change of code restarts the phase from zero, so the square wave never produces a fragment shorter than half the new period after the change.

All outputs are registered. A tick is a one-system-clock pulse in the cycle after the clock edge that consumed the qualifying reference pulse.

Top module: `rate_wave_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `per_tick`, `sec_tick` and `sqw_out` are all 0.
- R2: Divider select 3'b010 lets the chain advance on each `ref_en`. Selects 3'b110 and 3'b111 clear the chain, so no tick of any kind occurs. Every other select freezes the prescaler count and the rate phase; no tick occurs, and counting resumes from the frozen phase when 3'b010 returns.
- R3: After reset, or after release from a clearing select, the first `sec_tick` follows the 16384th counted `ref_en`; later ones follow every 32768th. `sec_tick` is a single-cycle pulse and occurs only in a cycle after a counted `ref_en`.
- R4: The `per_tick` period in counted `ref_en` pulses is 128 for rate code 1, 256 for code 2, and 2^(code-1) for codes 3 to 15 (4 for code 3, 16384 for code 15). `per_tick` is a single-cycle pulse.
- R5: With rate code 0 there is no `per_tick`, and `sqw_out` stays low.
- R6: With the square wave enabled and a nonzero code, `sqw_out` is low for the first half of each period and high for the second half. `sqw_out` changes one system clock after the phase counter.
- R7: `sqw_out` is low from the cycle after `sqw_en` is seen low.
- R8: A change of rate code restarts the phase at zero. The next `per_tick` comes one full new period of counted pulses later, and `sqw_out` goes low and stays low for the first half of that new period.
- R9: A clearing divider select also returns the rate phase to zero. After release, the first `per_tick` comes one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One pulse per reference clock period |
| div_sel | input | 3 | Divider selector (010 run, 11x clear, others freeze) |
| rate_sel | input | 4 | Periodic rate code, 0 = off |
| sqw_en | input | 1 | Square-wave output enable |
| per_tick | output | 1 | One-cycle pulse per selected period |
| sqw_out | output | 1 | Square wave at the selected rate |
| sec_tick | output | 1 | One-cycle pulse per second |

## Verification
A corrupted prescaler count shows up only as a misplaced `sec_tick`. That can stay hidden for up to 32768 reference pulses, so the bench measures the half-second first tick and a full second interval exactly. A wrong rate phase or a wrong terminal value shows within one period, as a displaced `per_tick` or an asymmetric `sqw_out` edge. The bench compares every output on every clock against its own model, under both dense and sparse `ref_en` patterns. A stale phase after a code change or a clear shows within the first new period, as an early tick or a short low phase.

// File: rtl/rwg_pkg.sv
package rwg_pkg;

    // Prescaler length for a 32.768 kHz reference: 2^15 pulses per second.
    localparam int unsigned CHAIN_W = 15;
    // Rate phase counter needs to reach 2^14 (the 2 Hz code).
    localparam int unsigned PHASE_W = CHAIN_W - 1;

    typedef enum logic [1:0] {
        DM_RUN   = 2'd0,
        DM_HOLD  = 2'd1,
        DM_CLEAR = 2'd2
    } div_mode_e;

    typedef struct packed {
        logic [3:0]         code;
        logic [PHASE_W-1:0] phase;
    } rate_state_t;

    function automatic div_mode_e div_decode(input logic [2:0] sel);
        if (sel[2:1] == 2'b11) return DM_CLEAR;
        if (sel == 3'b010)     return DM_RUN;
        return DM_HOLD;
    endfunction

    // Period of a rate code as a power of two of reference pulses; 0 = off.
    function automatic int unsigned rate_exp(input logic [3:0] code);
        case (code)
            4'd0:    return 0;
            4'd1:    return 7;
            4'd2:    return 8;
            default: return {28'd0, code} - 32'd1;
        endcase
    endfunction

endpackage

// File: rtl/rwg_prescale.sv
module rwg_prescale
    import rwg_pkg::*;
#(
    parameter int unsigned W = CHAIN_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ref_en,
    input  div_mode_e mode,
    output logic      step,
    output logic      sec_tick
);
    localparam logic [W-1:0] HALF = W'(1) << (W - 1);
    localparam logic [W-1:0] LAST = {W{1'b1}};

    logic [W-1:0] cnt;

    assign step = ref_en && (mode == DM_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= HALF;
            sec_tick <= 1'b0;
        end else begin
            sec_tick <= 1'b0;
            if (mode == DM_CLEAR) begin
                cnt <= HALF;
            end else if (step) begin
                cnt      <= cnt + 1'b1;
                sec_tick <= (cnt == LAST);
            end
        end
    end
endmodule

// File: rtl/rwg_rate_ctr.sv
module rwg_rate_ctr
    import rwg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic        clear,
    input  logic [3:0]  rate_sel,
    output rate_state_t st,
    output logic        per_tick
);
    int unsigned        e;
    logic [PHASE_W-1:0] lim;

    always_comb begin
        e   = rate_exp(st.code);
        lim = PHASE_W'((32'd1 << e) - 32'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            per_tick <= 1'b0;
        end else begin
            per_tick <= 1'b0;
            if (rate_sel != st.code) begin
                st.code  <= rate_sel;
                st.phase <= '0;
            end else if (clear) begin
                st.phase <= '0;
            end else if (step && st.code != 4'd0) begin
                if (st.phase == lim) begin
                    st.phase <= '0;
                    per_tick <= 1'b1;
                end else begin
                    st.phase <= st.phase + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rwg_wave_out.sv
module rwg_wave_out
    import rwg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sqw_en,
    input  rate_state_t st,
    output logic        sqw_out
);
    int unsigned        e;
    logic [PHASE_W-1:0] sh;
    logic               tap;

    always_comb begin
        e   = rate_exp(st.code);
        sh  = st.phase >> (e - 32'd1);
        tap = (e != 0) && sh[0];
    end

    always_ff @(posedge clk) begin
        if (rst) sqw_out <= 1'b0;
        else     sqw_out <= sqw_en && tap;
    end
endmodule

// File: rtl/rate_wave_gen.sv
module rate_wave_gen
    import rwg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_en,
    input  logic [2:0] div_sel,
    input  logic [3:0] rate_sel,
    input  logic       sqw_en,
    output logic       per_tick,
    output logic       sqw_out,
    output logic       sec_tick
);
    div_mode_e   mode;
    logic        step;
    rate_state_t st;

    assign mode = div_decode(div_sel);

    rwg_prescale #(.W(CHAIN_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .ref_en   (ref_en),
        .mode     (mode),
        .step     (step),
        .sec_tick (sec_tick)
    );

    rwg_rate_ctr u_rate (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .clear    (mode == DM_CLEAR),
        .rate_sel (rate_sel),
        .st       (st),
        .per_tick (per_tick)
    );

    rwg_wave_out u_wave (
        .clk     (clk),
        .rst     (rst),
        .sqw_en  (sqw_en),
        .st      (st),
        .sqw_out (sqw_out)
    );
endmodule

// File: rtl/rwg_checker.sv
module rwg_checker (
    input logic       clk,
    input logic       rst,
    input logic       ref_en,
    input logic [2:0] div_sel,
    input logic [3:0] rate_sel,
    input logic       sqw_en,
    input logic       per_tick,
    input logic       sqw_out,
    input logic       sec_tick
);
    assert_clear_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(div_sel[2:1]) == 2'b11) |-> !(sec_tick || per_tick));

    assert_no_ref_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(ref_en) |-> !(sec_tick || per_tick));

    assert_sec_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);

    assert_per_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        per_tick |=> !per_tick);

    assert_off_no_tick_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(rate_sel) == 4'd0) |-> !per_tick);

    assert_sqw_disabled_low_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(sqw_en) |-> !sqw_out);

    assert_change_restart_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(rate_sel) != $past(rate_sel, 2)) |-> !per_tick);
endmodule

bind rate_wave_gen rwg_checker u_chk (.*);

// File: tb/rate_wave_gen_test.sv
`timescale 1ns/1ps
module rate_wave_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_en = 1'b1;
    logic [2:0] div_sel = 3'b010;
    logic [3:0] rate_sel = 4'd0;
    logic       sqw_en = 1'b0;
    logic       per_tick, sqw_out, sec_tick;

    int checks = 0;
    int errors = 0;
    bit sparse = 1'b0;
    bit cmp_on = 1'b0;

    // reference model state
    int m_cnt = 16384, m_ph = 0, m_code = 0;
    bit e_per = 0, e_sec = 0, e_sqw = 0;

    rate_wave_gen uut (.*);

    always #2 clk = ~clk;

    always @(negedge clk) ref_en <= sparse ? ~ref_en : 1'b1;

    function automatic int period_exp(input int code);
        if (code == 0) return 0;
        if (code == 1) return 7;
        if (code == 2) return 8;
        return code - 1;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d exp %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model of the outputs, advanced on every clock edge
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 16384; m_ph = 0; m_code = 0;
            e_per = 0; e_sec = 0; e_sqw = 0;
        end else begin
            automatic int ex = period_exp(m_code);
            automatic bit counted = (div_sel == 3'b010) && ref_en;
            e_sqw = sqw_en && (ex != 0) && (((m_ph >> (ex - 1)) & 1) == 1);
            e_sec = 0;
            if (div_sel[2:1] == 2'b11) m_cnt = 16384;
            else if (counted) begin
                if (m_cnt == 32767) begin m_cnt = 0; e_sec = 1; end
                else m_cnt++;
            end
            e_per = 0;
            if (int'(rate_sel) != m_code) begin
                m_code = rate_sel; m_ph = 0;
            end else if (div_sel[2:1] == 2'b11) m_ph = 0;
            else if (counted && m_code != 0) begin
                if (m_ph == (1 << ex) - 1) begin m_ph = 0; e_per = 1; end
                else m_ph++;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check(per_tick === e_per, "R4 per_tick vs model", per_tick, e_per);
            check(sec_tick === e_sec, "R3 sec_tick vs model", sec_tick, e_sec);
            check(sqw_out === e_sqw, "R6 sqw_out vs model", sqw_out, e_sqw);
        end
    end

    task automatic wait_per(input int maxc, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!per_tick && n < maxc);
    endtask

    task automatic wait_sec(input int maxc, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!sec_tick && n < maxc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, seen;
        @(posedge clk); #1 cmp_on = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state
        check(!per_tick && !sec_tick && !sqw_out, "R1 outputs in reset",
              {per_tick, sec_tick, sqw_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!per_tick && !sec_tick && !sqw_out, "R1 outputs after reset",
              {per_tick, sec_tick, sqw_out}, 0);

        // R4/R8: code 3 after a change, then steady period
        rate_sel = 4'd3;
        wait_per(100, n);  check(n == 5, "R8 first tick after change code 3", n, 5);
        wait_per(100, n);  check(n == 4, "R4 period code 3", n, 4);

        // R4 with sparse reference pulses
        sparse = 1'b1;
        wait_per(100, n);
        wait_per(100, n);  check(n == 8, "R4 period code 3 sparse ref", n, 8);
        sparse = 1'b0;

        rate_sel = 4'd1;
        wait_per(400, n);
        wait_per(400, n);  check(n == 128, "R4 period code 1", n, 128);
        rate_sel = 4'd2;
        wait_per(600, n);
        wait_per(600, n);  check(n == 256, "R4 period code 2", n, 256);

        // R8/R6: square wave after change to code 4 (period 8)
        rate_sel = 4'd4; sqw_en = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!sqw_out && n < 50);
        check(n == 6, "R8 low phase after change code 4", n, 6);
        n = 0;
        while (sqw_out && n < 50) begin @(negedge clk); n++; end
        check(n == 4, "R6 high half code 4", n, 4);
        n = 0;
        while (!sqw_out && n < 50) begin @(negedge clk); n++; end
        check(n == 4, "R6 low half code 4", n, 4);

        // R7: disable square wave
        sqw_en = 1'b0;
        seen = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); seen += sqw_out; end
        check(seen == 0, "R7 sqw low when disabled", seen, 0);

        // R5: code 0
        sqw_en = 1'b1; rate_sel = 4'd0;
        seen = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); seen += per_tick + sqw_out; end
        check(seen == 0, "R5 code 0 silent", seen, 0);

        // R2: freeze with a non-running select
        rate_sel = 4'd3;
        wait_per(100, n);
        div_sel = 3'b000;
        seen = 0;
        for (int i = 0; i < 50; i++) begin @(negedge clk); seen += per_tick + sec_tick; end
        check(seen == 0, "R2 no tick while frozen", seen, 0);
        div_sel = 3'b101;
        for (int i = 0; i < 20; i++) begin @(negedge clk); seen += per_tick + sec_tick; end
        check(seen == 0, "R2 no tick with test select", seen, 0);
        div_sel = 3'b010;
        wait_per(100, n);  check(n == 4, "R2 resume from frozen phase", n, 4);

        // R9: clear restarts rate phase (code 5, period 16)
        rate_sel = 4'd5;
        wait_per(100, n);
        repeat (5) @(negedge clk);
        div_sel = 3'b110;
        seen = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); seen += per_tick + sec_tick; end
        check(seen == 0, "R2 no tick while cleared", seen, 0);
        div_sel = 3'b010;
        wait_per(100, n);  check(n == 16, "R9 full period after clear", n, 16);

        // R3: half-second first tick after release, then one second
        div_sel = 3'b111;
        repeat (3) @(negedge clk);
        div_sel = 3'b010;
        wait_sec(40000, n); check(n == 16384, "R3 first second tick", n, 16384);
        wait_sec(40000, n); check(n == 32768, "R3 second interval", n, 32768);

        // R4: slowest code
        rate_sel = 4'd15;
        wait_per(20000, n);
        wait_per(20000, n); check(n == 16384, "R4 period code 15", n, 16384);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule